// File: doc/BRIEF.md
# Level-Match GPIO Controller

This block is a 32-pin general-purpose I/O controller. Software reaches it through a small bank of six 32-bit registers behind a word-wide request/response bus. In each register, each bit belongs to one pin. Per pin, software chooses whether the pin stays a GPIO or is given to an alternate function, and whether it is an input or an output. A data register sets the value driven on output pins. Reading that register returns the synchronized state of all pins.

Every pin has a programmable match level. While the synchronized pin value equals that level, the pin's status bit is set. A status bit is sticky and stays set until software writes 1 to it. If the match is still present in the cycle of the clear, the set wins. A per-pin enable selects which status bits drive the single non-maskable interrupt output.

The bus side is a valid/ready request channel with a valid/ready response channel. Every accepted request, read or write, returns exactly one response, in order. There is one response slot. When a response is held because `rsp_ready` is low, `req_ready` drops and no new request is accepted until the response is taken. `rsp_rdata` stays stable while it is held.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: While `rst_n` is low, every register is zero. `pin_oe`, `alt_sel` and `pin_out` are zero, `nmi_out` is low and `rsp_valid` is low. All pins therefore come up as GPIO inputs with the interrupt disabled.
- R2: The word index `req_addr[7:2]` selects a register. A request is mapped only when `req_addr[1:0]` is 0.
  - Index 0 (byte 0x00) is function select.
  - Index 1 (0x04) is direction.
  - Index 2 (0x08) is data.
  - Index 3 (0x0C) is match level.
  - Index 4 (0x10) is status.
  - Index 5 (0x14) is interrupt enable.
  - Function select, direction, level and enable read back what was written.
  - An unmapped read returns 0. An unmapped write changes nothing.
- R3: `alt_sel` equals the function select register, where 1 means alternate function. `pin_out` equals the data register. `pin_oe[i]` is 1 exactly when function bit i is 0 and direction bit i is 1, where 1 means output.
- R4: A data register read returns `pin_in` after a two-flop synchronizer.
  - A read accepted at the first or second rising edge after a pin change returns the old value.
  - A read accepted at the third rising edge returns the new value.
- R5: A status bit is set at the clock edge after the synchronized pin value equals its level bit. This is the third rising edge after the pin change. A status bit never sets without such a match.
- R6: A set status bit stays set after the match goes away, until it is cleared.
- R7: Writing to status clears the bits written as 1 and leaves the bits written as 0 unchanged. If a pin still matches in the cycle of the clear, its bit stays set.
- R8: `nmi_out` is high exactly when some pin has both its status bit and its enable bit set.
- R9: Bus handshake rules.
  - A request is accepted when `req_valid` and `req_ready` are both high.
  - `req_ready` is low while a response is held with `rsp_ready` low.
  - Each accepted request yields one response, in order.
  - A write response carries 0.
  - A held response keeps its data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pin_in | input | 32 | Pin values from the pads |
| pin_out | output | 32 | Values to drive on output pins |
| pin_oe | output | 32 | Per-pin output enable |
| alt_sel | output | 32 | Per-pin alternate-function select |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
A status bit can be set by a pin match and cleared by a software write in the same cycle. The bench provokes this by holding a pin at its level while writing 1 to its status bit. It then judges the result by reading status back and expecting the bit still set, because the set takes priority. It also uses `nmi_out` to time the set edge exactly after a pin change. Back-pressure on the response channel overlaps new requests with held responses, and the scoreboard checks order and data through those stalls.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  // Word indices of the register bank; software relies on this order.
  localparam int unsigned IDX_FUNC   = 0;
  localparam int unsigned IDX_DIR    = 1;
  localparam int unsigned IDX_DATA   = 2;
  localparam int unsigned IDX_LEVEL  = 3;
  localparam int unsigned IDX_STATUS = 4;
  localparam int unsigned IDX_NMIEN  = 5;
  localparam int unsigned NUM_REGS   = 6;

  // Slots inside the plain read/write register file.
  localparam int unsigned SLOT_FUNC  = 0;
  localparam int unsigned SLOT_DIR   = 1;
  localparam int unsigned SLOT_DATA  = 2;
  localparam int unsigned SLOT_LEVEL = 3;
  localparam int unsigned SLOT_NMIEN = 4;
  localparam int unsigned NUM_RW     = 5;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_lvl_busif.sv
module gpio_lvl_busif #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 6,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  // towards the register bank
  output logic              wr_en,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] rd_word
);
  logic accept;
  logic mapped;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign acc_idx   = req_addr[ADDR_W-1:2];
  assign acc_wdata = req_wdata;
  assign mapped    = (req_addr[1:0] == 2'b00) && (acc_idx < IDX_W'(NUM_REGS));
  assign wr_en     = accept && req_write && mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (!req_write && mapped) ? rd_word : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_lvl_cfg.sv
module gpio_lvl_cfg #(
  parameter int WIDTH = 32,
  parameter int COUNT = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [COUNT-1:0]            we,
  input  logic [WIDTH-1:0]            wdata,
  output logic [COUNT-1:0][WIDTH-1:0] q
);
  generate
    for (genvar r = 0; r < COUNT; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q[r] <= '0;
        else if (we[r]) q[r] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_lvl_status.sv
module gpio_lvl_status #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_sync,
  input  logic [PINS-1:0] level,
  input  logic [PINS-1:0] clr,
  input  logic [PINS-1:0] enable,
  output logic [PINS-1:0] status,
  output logic            irq
);
  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic hit;
      assign hit = (pin_sync[i] == level[i]);
      // Set has priority over a same-cycle clear.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status[i] <= 1'b0;
        else        status[i] <= hit || (status[i] && !clr[i]);
      end
    end
  endgenerate

  assign irq = |(status & enable);
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PINS-1:0]   req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PINS-1:0]   rsp_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   alt_sel,
  output logic              nmi_out
);
  localparam int IDX_W = ADDR_W - 2;

  logic                       wr_en;
  logic [IDX_W-1:0]           acc_idx;
  logic [PINS-1:0]            acc_wdata;
  logic [PINS-1:0]            rd_word;
  logic [NUM_RW-1:0]          rw_we;
  logic [NUM_RW-1:0][PINS-1:0] rw_q;
  logic [PINS-1:0]            pin_sync;
  logic [PINS-1:0]            level_q;
  logic [PINS-1:0]            status_q;
  logic [PINS-1:0]            clr_mask;

  gpio_lvl_busif #(.ADDR_W(ADDR_W), .DATA_W(PINS), .NUM_REGS(NUM_REGS)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wr_en(wr_en), .acc_idx(acc_idx), .acc_wdata(acc_wdata), .rd_word(rd_word)
  );

  // Write strobes for the plain registers.
  always_comb begin
    rw_we = '0;
    if (wr_en) begin
      case (acc_idx)
        IDX_W'(IDX_FUNC):  rw_we[SLOT_FUNC]  = 1'b1;
        IDX_W'(IDX_DIR):   rw_we[SLOT_DIR]   = 1'b1;
        IDX_W'(IDX_DATA):  rw_we[SLOT_DATA]  = 1'b1;
        IDX_W'(IDX_LEVEL): rw_we[SLOT_LEVEL] = 1'b1;
        IDX_W'(IDX_NMIEN): rw_we[SLOT_NMIEN] = 1'b1;
        default:           rw_we = '0;
      endcase
    end
  end

  assign clr_mask = (wr_en && acc_idx == IDX_W'(IDX_STATUS)) ? acc_wdata : '0;

  gpio_lvl_cfg #(.WIDTH(PINS), .COUNT(NUM_RW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(rw_we), .wdata(acc_wdata), .q(rw_q)
  );

  gpio_lvl_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign level_q = rw_q[SLOT_LEVEL];

  gpio_lvl_status #(.PINS(PINS)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .pin_sync(pin_sync), .level(level_q), .clr(clr_mask),
    .enable(rw_q[SLOT_NMIEN]), .status(status_q), .irq(nmi_out)
  );

  // Read selection; data reads return synchronized pins.
  always_comb begin
    case (acc_idx)
      IDX_W'(IDX_FUNC):   rd_word = rw_q[SLOT_FUNC];
      IDX_W'(IDX_DIR):    rd_word = rw_q[SLOT_DIR];
      IDX_W'(IDX_DATA):   rd_word = pin_sync;
      IDX_W'(IDX_LEVEL):  rd_word = level_q;
      IDX_W'(IDX_STATUS): rd_word = status_q;
      IDX_W'(IDX_NMIEN):  rd_word = rw_q[SLOT_NMIEN];
      default:            rd_word = '0;
    endcase
  end

  assign alt_sel = rw_q[SLOT_FUNC];
  assign pin_out = rw_q[SLOT_DATA];
  assign pin_oe  = ~rw_q[SLOT_FUNC] & rw_q[SLOT_DIR];
endmodule

// File: rtl/gpio_lvl_ctrl_chk.sv
module gpio_lvl_ctrl_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PINS-1:0] rsp_rdata,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] alt_sel,
  input logic [PINS-1:0] pin_out,
  input logic            nmi_out,
  input logic [PINS-1:0] sync_q,
  input logic [PINS-1:0] level_q,
  input logic [PINS-1:0] status_q,
  input logic [PINS-1:0] clr_mask
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (pin_oe == '0 && alt_sel == '0 && pin_out == '0
                                     && !nmi_out && !rsp_valid && status_q == '0);
    end
  end

  assert_oe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & alt_sel) == '0);

  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sync_q ~^ level_q) & ~status_q) == '0));

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(sync_q ~^ level_q)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

  assert_nmi_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> (status_q != '0));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind gpio_lvl_ctrl gpio_lvl_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pin_oe(pin_oe),
  .alt_sel(alt_sel), .pin_out(pin_out), .nmi_out(nmi_out),
  .sync_q(pin_sync), .level_q(level_q), .status_q(status_q), .clr_mask(clr_mask)
);

// File: tb/tb_gpio_lvl_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_lvl_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, alt_sel;
  logic        nmi_out;

  always #2.5 clk = ~clk;

  gpio_lvl_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .nmi_out(nmi_out)
  );

  localparam logic [7:0] A_FUNC = 8'h00, A_DIR = 8'h04, A_DATA = 8'h08,
                         A_LVL = 8'h0C, A_STAT = 8'h10, A_EN = 8'h14;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp = 1'b0;
  bit bp_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the falling edge after acceptance.
  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] e, input string tag);
    exp_q.push_back(wr ? 32'h0 : e);
    tag_q.push_back(tag);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Response back-pressure pattern, changed away from both edges.
  always @(posedge clk) begin
    #1;
    cyc++;
    rsp_ready = bp ? (cyc % 3 == 0) : 1'b1;
  end

  // Monitor: a response is taken at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
    if (bp && rsp_valid && !rsp_ready && !bp_seen) begin
      bp_seen = 1'b1;
      check("R9 req_ready low while response held", {31'b0, req_ready}, 32'h0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    check("R1 pin_oe in reset", pin_oe, 32'h0);
    check("R1 alt_sel in reset", alt_sel, 32'h0);
    check("R1 pin_out in reset", pin_out, 32'h0);
    check("R1 nmi_out in reset", {31'b0, nmi_out}, 32'h0);
    check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    idle(3);
    // Pins low and level zero match everywhere.
    bus(0, A_STAT, 0, 32'hFFFF_FFFF, "R5 all pins match after reset");
    bus(0, A_FUNC, 0, 32'h0, "R1 function select reset value");
    bus(0, A_EN, 0, 32'h0, "R1 enable reset value");
    idle(1);
    check("R8 nmi low with enables zero", {31'b0, nmi_out}, 32'h0);
    pin_in = 32'hFFFF_FFFF;
    idle(4);
    bus(1, A_STAT, 32'hFFFF_FFFF, 0, "R9 write response");
    bus(0, A_STAT, 0, 32'h0, "R7 clear all status");

    // Register map and output rules
    bus(1, A_FUNC, 32'h0F0F_00FF, 0, "R2 write func");
    bus(1, A_DIR,  32'h00FF_F0F0, 0, "R2 write dir");
    bus(1, A_DATA, 32'h1234_5678, 0, "R2 write data");
    bus(1, A_LVL,  32'h8000_0001, 0, "R2 write level");
    bus(1, A_EN,   32'hA5A5_0000, 0, "R2 write enable");
    bus(1, 8'h18,  32'hFFFF_FFFF, 0, "R2 unmapped write");
    bus(1, 8'h01,  32'hFFFF_FFFF, 0, "R2 misaligned write");
    bus(0, A_FUNC, 0, 32'h0F0F_00FF, "R2 func readback");
    bus(0, A_DIR,  0, 32'h00FF_F0F0, "R2 dir readback");
    bus(0, A_LVL,  0, 32'h8000_0001, "R2 level readback");
    bus(0, A_EN,   0, 32'hA5A5_0000, "R2 enable readback");
    bus(0, 8'h18,  0, 32'h0, "R2 unmapped read");
    bus(0, A_DATA, 0, 32'hFFFF_FFFF, "R4 data read returns pins");
    check("R3 alt_sel follows func", alt_sel, 32'h0F0F_00FF);
    check("R3 pin_out follows data", pin_out, 32'h1234_5678);
    check("R3 pin_oe gpio outputs only", pin_oe, 32'h00F0_F000);
    bus(1, A_FUNC, 32'h0, 0, "R3 func to gpio");
    check("R3 pin_oe equals dir when all gpio", pin_oe, 32'h00FF_F0F0);
    bus(1, A_LVL, 32'h0, 0, "R2 level zero");
    bus(1, A_EN, 32'h0, 0, "R2 enable zero");
    bus(1, A_DIR, 32'h0, 0, "R2 dir zero");

    // Synchronizer latency
    pin_in = 32'hCAFE_F00D;
    bus(0, A_DATA, 0, 32'hFFFF_FFFF, "R4 first edge old value");
    bus(0, A_DATA, 0, 32'hFFFF_FFFF, "R4 second edge old value");
    bus(0, A_DATA, 0, 32'hCAFE_F00D, "R4 third edge new value");
    pin_in = 32'hFFFF_FFFF;
    idle(4);
    bus(1, A_STAT, 32'hFFFF_FFFF, 0, "R7 clear");
    bus(0, A_STAT, 0, 32'h0, "R7 status clear before match tests");

    // Set timing seen at nmi_out
    bus(1, A_EN, 32'h0000_0020, 0, "R8 enable pin 5");
    pin_in[5] = 1'b0;
    idle(2);
    check("R5 not set after two edges", {31'b0, nmi_out}, 32'h0);
    idle(1);
    check("R5 set on third edge", {31'b0, nmi_out}, 32'h1);

    // Sticky
    pin_in[3] = 1'b0;
    idle(5);
    pin_in[3] = 1'b1;
    idle(5);
    bus(0, A_STAT, 0, 32'h0000_0028, "R6 bit stays after match ends");
    bus(1, A_EN, 32'h0, 0, "R8 enable off");
    check("R8 nmi low with status but no enable", {31'b0, nmi_out}, 32'h0);
    bus(1, A_EN, 32'h0000_0008, 0, "R8 enable pin 3");
    check("R8 nmi high on enabled status", {31'b0, nmi_out}, 32'h1);

    // Clearing rules
    bus(1, A_STAT, 32'h0, 0, "R7 zero write");
    bus(0, A_STAT, 0, 32'h0000_0028, "R7 zeros leave bits");
    bus(1, A_STAT, 32'h0000_0008, 0, "R7 clear pin 3");
    bus(0, A_STAT, 0, 32'h0000_0020, "R7 only pin 3 cleared");
    check("R8 nmi low after clear", {31'b0, nmi_out}, 32'h0);
    bus(1, A_STAT, 32'h0000_0020, 0, "R7 clear during match");
    bus(0, A_STAT, 0, 32'h0000_0020, "R7 set wins over clear");
    pin_in[5] = 1'b1;
    idle(4);
    bus(1, A_STAT, 32'h0000_0020, 0, "R7 clear after match");
    bus(0, A_STAT, 0, 32'h0, "R7 cleared after match ends");

    // Back-pressure
    bp = 1'b1;
    bus(1, A_FUNC, 32'h1111_1111, 0, "R9 bp write");
    bus(0, A_FUNC, 0, 32'h1111_1111, "R9 bp read func");
    bus(1, A_DIR, 32'h2222_2222, 0, "R9 bp write dir");
    bus(0, A_DIR, 0, 32'h2222_2222, "R9 bp read dir");
    bus(0, 8'h3C, 0, 32'h0, "R9 bp unmapped read");
    bus(0, A_FUNC, 0, 32'h1111_1111, "R9 bp read func again");
    bp = 1'b0;
    idle(8);
    check("R9 every request answered", exp_q.size(), 32'h0);
    check("R9 stall observed", {31'b0, bp_seen}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule